// File: doc/BRIEF.md
# Sliced Unsigned Magnitude Comparator with Output Enable

This block compares two unsigned binary operands and reports whether the first is greater than, less than or equal to the second. It has no clock and no state. The operands are split into fixed-width slices, and a compare cell handles each slice. Each cell produces its own greater and less results, and derives its equal result as "neither greater nor less". A chain of merge stages then folds the slice results together from the most significant slice down. At each stage the more significant result wins, and the less significant result counts only when the more significant slices are equal.

By default the operands are 8 bits wide, built from two 4-bit slices. An active-high output enable gates all three flags. While the enable is low the block reports nothing: every flag is 0. The slice cell comes in two variants, selected by a parameter. One uses a direct arithmetic compare. The other scans the bits from least to most significant, so that a higher differing bit overrides a lower one.

Top module: `mag_cmp8_en`

## Requirements
- R1: With `out_en`=1 and `opa` greater than `opb` as unsigned numbers, `is_gt` is 1 and `is_lt`, `is_eq` are 0.
- R2: With `out_en`=1 and `opa` less than `opb` as unsigned numbers, `is_lt` is 1 and `is_gt`, `is_eq` are 0.
- R3: With `out_en`=1 and `opa` equal to `opb`, `is_eq` is 1 and `is_gt`, `is_lt` are 0, including at 0x00 and 0xFF.
- R4: With `out_en`=0, `is_gt`, `is_lt` and `is_eq` are all 0 for any operands.
- R5: With `out_en`=1, exactly one of the three flags is 1 for every operand pair.
- R6: When the upper 4-bit nibbles differ, the result follows the upper nibbles alone, even when the lower nibbles order the other way (for example 0x20 vs 0x1F gives greater).
- R7: Each 4-bit compare cell gives greater and less results that are never both 1, and equal is 1 exactly when both are 0. This holds for all 256 input pairs, in both cell variants (variant 0 arithmetic, variant 1 bit scan).
- R8: Comparison is unsigned: 0x80 against 0x7F gives greater, and 0x00 against 0xFF gives less.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 8 | First operand, unsigned |
| opb | input | 8 | Second operand, unsigned |
| out_en | input | 1 | Active-high enable for all three flags |
| is_gt | output | 1 | opa greater than opb |
| is_lt | output | 1 | opa less than opb |
| is_eq | output | 1 | opa equal to opb |

## Verification
The block holds no state, so any fault shows up at the ports within the same evaluation as the operands that expose it. A cell that mis-orders one bit pair, or a merge that lets the lower slice override a differing upper slice, flips a flag for only the operand pairs that reach that path. For this reason the bench sweeps every 4-bit cell input exhaustively, and it runs opposing-nibble pairs such as 0x20 against 0x1F. A broken derivation of equal from greater and less appears as zero or two flags high at once. A fault in the enable gating shows flags while the enable is low.

// File: rtl/mag_cmp_pkg.sv
`timescale 1ns/1ps
package mag_cmp_pkg;

   // result of one slice or one merged group of slices
   typedef struct packed {
      logic gt;
      logic lt;
      logic eq;
   } cmp_res_t;

   localparam int STYLE_ARITH = 0;
   localparam int STYLE_SCAN  = 1;

   function automatic cmp_res_t res_equal();
      cmp_res_t r;
      r.gt = 1'b0;
      r.lt = 1'b0;
      r.eq = 1'b1;
      return r;
   endfunction

endpackage

// File: rtl/mag_slice_cmp.sv
`timescale 1ns/1ps
module mag_slice_cmp
   import mag_cmp_pkg::*;
#(
   parameter int SLICE_W = 4,
   parameter int STYLE   = STYLE_SCAN
) (
   input  logic [SLICE_W-1:0] sa,
   input  logic [SLICE_W-1:0] sb,
   output cmp_res_t           res
);

   if (SLICE_W < 1) begin : g_bad_width
      $error("mag_slice_cmp: SLICE_W must be at least 1");
   end
   if (STYLE != STYLE_ARITH && STYLE != STYLE_SCAN) begin : g_bad_style
      $error("mag_slice_cmp: unknown STYLE");
   end

   logic sg;
   logic sl;

   if (STYLE == STYLE_ARITH) begin : g_arith
      assign sg = (sa > sb);
      assign sl = (sa < sb);
   end else begin : g_scan
      // walk upward; a higher differing bit overrides any lower one
      always_comb begin
         sg = 1'b0;
         sl = 1'b0;
         for (int i = 0; i < SLICE_W; i++) begin
            if (sa[i] && !sb[i]) begin
               sg = 1'b1;
               sl = 1'b0;
            end else if (!sa[i] && sb[i]) begin
               sg = 1'b0;
               sl = 1'b1;
            end
         end
      end
   end

   // equal is derived from the ordering results, no separate equality tree
   assign res.gt = sg;
   assign res.lt = sl;
   assign res.eq = ~(sg | sl);

   always_comb begin
      if (!$isunknown({sa, sb, sg, sl})) begin
         p_gt_lt_excl_r7: assert (!(sg && sl));
         p_equal_means_same_r7: assert ((sg || sl) == (sa != sb));
      end
   end

endmodule

// File: rtl/mag_merge.sv
`timescale 1ns/1ps
module mag_merge
   import mag_cmp_pkg::*;
(
   input  cmp_res_t hi,
   input  cmp_res_t lo,
   output cmp_res_t res
);

   logic mg;
   logic ml;

   // the more significant group dominates; the lower one decides only on a tie
   assign mg = hi.gt | (hi.eq & lo.gt);
   assign ml = hi.lt | (hi.eq & lo.lt);

   assign res.gt = mg;
   assign res.lt = ml;
   assign res.eq = ~(mg | ml);

   always_comb begin
      if (!$isunknown({hi, lo, mg, ml})) begin
         p_hi_dominates_r6: assert (!(hi.gt || hi.lt) || (mg == hi.gt && ml == hi.lt));
         p_lo_on_tie_r6: assert (!hi.eq || (mg == lo.gt && ml == lo.lt));
         p_lo_eq_excl_r7: assert (!(lo.eq && (lo.gt || lo.lt)));
      end
   end

endmodule

// File: rtl/mag_cmp8_en.sv
`timescale 1ns/1ps
module mag_cmp8_en
   import mag_cmp_pkg::*;
#(
   parameter int SLICE_W    = 4,
   parameter int NUM_SLICES = 2,
   parameter int CELL_STYLE = STYLE_SCAN,
   localparam int WIDTH     = SLICE_W * NUM_SLICES
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             out_en,
   output logic             is_gt,
   output logic             is_lt,
   output logic             is_eq
);

   if (NUM_SLICES < 1) begin : g_bad_count
      $error("mag_cmp8_en: NUM_SLICES must be at least 1");
   end

   cmp_res_t slice_res [NUM_SLICES];
   cmp_res_t chain     [NUM_SLICES+1];

   assign chain[NUM_SLICES] = res_equal();

   for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
      mag_slice_cmp #(
         .SLICE_W (SLICE_W),
         .STYLE   (CELL_STYLE)
      ) u_cell (
         .sa  (opa[s*SLICE_W +: SLICE_W]),
         .sb  (opb[s*SLICE_W +: SLICE_W]),
         .res (slice_res[s])
      );

      mag_merge u_merge (
         .hi  (chain[s+1]),
         .lo  (slice_res[s]),
         .res (chain[s])
      );
   end

   assign is_gt = out_en & chain[0].gt;
   assign is_lt = out_en & chain[0].lt;
   assign is_eq = out_en & chain[0].eq;

   always_comb begin
      if (!$isunknown({out_en, is_gt, is_lt, is_eq})) begin
         p_quiet_when_off_r4: assert (out_en || {is_gt, is_lt, is_eq} == 3'b000);
         p_one_flag_r5: assert (!out_en || $countones({is_gt, is_lt, is_eq}) == 1);
      end
   end

endmodule

// File: tb/mag_cmp8_en_test.sv
`timescale 1ns/1ps
module mag_cmp8_en_test;
   import mag_cmp_pkg::*;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;   // 50 MHz

   logic [7:0] a = '0;
   logic [7:0] b = '0;
   logic       en = 1'b0;
   logic       gt, lt, eq;

   logic [3:0] ca = '0;
   logic [3:0] cb = '0;
   cmp_res_t   cr_arith, cr_scan;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   mag_cmp8_en uut (
      .opa(a), .opb(b), .out_en(en),
      .is_gt(gt), .is_lt(lt), .is_eq(eq)
   );

   mag_slice_cmp #(.SLICE_W(4), .STYLE(STYLE_ARITH)) cell_arith (
      .sa(ca), .sb(cb), .res(cr_arith)
   );
   mag_slice_cmp #(.SLICE_W(4), .STYLE(STYLE_SCAN)) cell_scan (
      .sa(ca), .sb(cb), .res(cr_scan)
   );

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // drive after a falling edge, sample shortly after the next rising edge
   task automatic apply(input logic [7:0] va, input logic [7:0] vb,
                        input logic ven, input string tag);
      int ia, ib;
      logic [2:0] exp, got;
      @(negedge clk);
      a = va; b = vb; en = ven;
      @(posedge clk);
      #2;
      ia = int'(va);
      ib = int'(vb);
      if (!ven) exp = 3'b000;
      else if (ia > ib) exp = 3'b100;
      else if (ia < ib) exp = 3'b010;
      else exp = 3'b001;
      got = {gt, lt, eq};
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s a=%02h b=%02h en=%0b got gt/lt/eq=%03b exp=%03b",
                  tag, va, vb, ven, got, exp);
      end
   endtask

   function automatic string tag_of(logic [7:0] va, logic [7:0] vb, logic ven);
      if (!ven) return "R4";
      if (va > vb) return "R1 R5";
      if (va < vb) return "R2 R5";
      return "R3 R5";
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog: run did not complete, got hung exp=complete");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // reset state: enable low, all flags quiet (R4)
      total++;
      if ({gt, lt, eq} !== 3'b000) begin
         bad++;
         $display("FAIL R4 reset state got=%03b exp=000", {gt, lt, eq});
      end
      rst = 1'b0;

      // R7: every 4-bit cell input pair, both variants
      for (int x = 0; x < 16; x++) begin
         for (int y = 0; y < 16; y++) begin
            logic [2:0] ce;
            @(negedge clk);
            ca = 4'(x); cb = 4'(y);
            @(posedge clk);
            #2;
            ce = (x > y) ? 3'b100 : (x < y) ? 3'b010 : 3'b001;
            total++;
            if (cr_arith !== ce || cr_scan !== ce) begin
               bad++;
               $display("FAIL R7 cell a=%0d b=%0d got arith=%03b scan=%03b exp=%03b",
                        x, y, cr_arith, cr_scan, ce);
            end
         end
      end

      // directed corners
      apply(8'h00, 8'h00, 1'b1, "R3 zero");
      apply(8'hFF, 8'hFF, 1'b1, "R3 all-ones");
      apply(8'h80, 8'h7F, 1'b1, "R8 msb");
      apply(8'h00, 8'hFF, 1'b1, "R8 extremes");
      apply(8'hFF, 8'h00, 1'b1, "R1 extremes");
      apply(8'h20, 8'h1F, 1'b1, "R6 hi wins gt");
      apply(8'h1F, 8'h20, 1'b1, "R6 hi wins lt");
      apply(8'h3A, 8'h39, 1'b1, "R1 lo decides");
      apply(8'h39, 8'h3A, 1'b1, "R2 lo decides");
      apply(8'hFF, 8'h00, 1'b0, "R4 off gt");
      apply(8'h55, 8'h55, 1'b0, "R4 off eq");
      apply(8'h00, 8'hFF, 1'b0, "R4 off lt");

      // random pairs with forced equal / zero / all-ones operands
      for (int i = 0; i < 10500; i++) begin
         logic [7:0] ra, rb;
         logic ren;
         ra = 8'($urandom);
         rb = 8'($urandom);
         case (i % 8)
            0: rb = ra;
            1: ra = 8'h00;
            2: rb = 8'hFF;
            3: rb = {ra[7:4], rb[3:0]};
            default: ;
         endcase
         ren = (i % 10) != 9;
         apply(ra, rb, ren, tag_of(ra, rb, ren));
      end

      done = 1'b1;
      finish_run();
   end

endmodule